// File: doc/BRIEF.md
# Serial ADC configuration and readout sequencer

This block drives an external delta-sigma converter over a four-wire serial link. On a start request it opens with a fixed configuration burst. The burst selects and writes the converter's clock register, then selects and writes its setup register. The setup write launches a self-calibration. After that the block watches the converter's active-low data-ready line and fetches a requested number of 16-bit conversion results, one at a time.

Every converter access begins with a command byte. Bits 6:4 of that byte name the target register and bit 3 sets the direction. A sample fetch is therefore one command byte followed by two read bytes. Each finished sample appears on a data output together with a one-cycle valid strobe. A done flag rises once the requested count has been delivered and stays up until the next start.

The serial clock comes from the system clock through a parameterized divider. Each byte is framed by its own chip-select window.

Top module: `adc_seq_top`

## Requirements
- R1: While rst_n is low and after its release: cs_n = 1, sclk = 1, sample_valid = 0, done = 0.
- R2: The link uses SPI mode 3. sclk idles high, and mosi changes only while sclk is low, so it is stable on every rising sclk edge. Bits go out and come in MSB first.
- R3: Every byte has its own chip-select window with exactly 8 rising sclk edges. Three spacings are each at least 2*HALF_DIV clocks: cs_n fall to the first sclk fall, the last sclk rise to cs_n rise, and cs_n rise to the next cs_n fall.
- R4: After start, the first four bytes sent are 0x20, 0x0C, 0x10 and 0x40, in that order. A command byte carries the register select in bits 6:4 (clock = 010, setup = 001, data = 011) and read = 1 / write = 0 in bit 3.
- R5: After the configuration burst, no byte is sent until drdy_n is low. cs_n falls on the 4th rising clock edge after drdy_n goes low.
- R6: Each sample is fetched as the command byte 0x38 followed by two read bytes. During the read bytes, mosi stays 1.
- R7: The first read byte is placed in sample_data[15:8] and the second in [7:0]. sample_valid is high for exactly one clock per sample, and it rises 2*HALF_DIV clocks after the cs_n rise that ends the second read byte.
- R8: Before every sample after the first, drdy_n must first be seen high and then low. A drdy_n that simply stays low triggers no further read.
- R9: done rises with the last sample's valid strobe and holds, with no further serial traffic, until the next start.
- R10: start is accepted only when idle or done, and sample_count is latched at that moment. A start during a sequence is ignored. A start after done reruns the whole configuration.
- R11: With sample_count = 0, done rises after the configuration burst and no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration and readout sequence |
| sample_count | input | CNT_W | Number of samples to fetch, latched at start |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the converter |
| sample_valid | output | 1 | One-cycle strobe for each finished sample |
| sample_data | output | 16 | Assembled sample, first byte in the high half |
| done | output | 1 | Requested count delivered |

## Verification
Three results have timing that can be counted exactly, and the bench checks each one at that clock. After drdy_n drops on a falling clock edge, cs_n is expected high at the third falling edge that follows and low at the fourth, because two synchronizer flops, one controller step and the byte launch lie on the path. A sample's strobe must arrive exactly 2*HALF_DIV clocks after the chip-select rise that closes its second read byte, so the bench checks the strobe half a clock after that edge. Waits on data-ready and on done are checked over whole windows that are longer than the longest latency, and byte order is checked against a log taken at each chip-select rise.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Converter register select codes (command byte bits 6:4)
  typedef enum logic [2:0] {
    SEL_COMM  = 3'b000,
    SEL_SETUP = 3'b001,
    SEL_CLOCK = 3'b010,
    SEL_DATA  = 3'b011,
    SEL_TEST  = 3'b100,
    SEL_ZCAL  = 3'b110,
    SEL_FCAL  = 3'b111
  } reg_sel_e;

  // Byte engine states
  typedef enum logic [2:0] {
    E_IDLE, E_SETUP, E_LOW, E_HIGH, E_HOLD, E_GAP
  } eng_st_e;

  // Sequencer states
  typedef enum logic [2:0] {
    C_IDLE, C_CFG, C_WAIT_HI, C_WAIT_LO, C_CMD, C_RDH, C_RDL, C_DONE
  } ctl_st_e;

  localparam int          CFG_LEN   = 4;
  localparam logic [7:0]  CLOCK_VAL = 8'h0C;  // clock on, 50 Hz output rate
  localparam logic [7:0]  SETUP_VAL = 8'h40;  // self-cal, gain 1, bipolar, unbuffered
  localparam logic [7:0]  IDLE_TX   = 8'hFF;

  // Command byte: bit 7 zero, select in 6:4, read flag in 3
  function automatic logic [7:0] cmd_byte(reg_sel_e sel, logic rd);
    return {1'b0, sel, rd, 3'b000};
  endfunction

  function automatic logic [7:0] cfg_byte(logic [1:0] idx);
    case (idx)
      2'd0:    return cmd_byte(SEL_CLOCK, 1'b0);
      2'd1:    return CLOCK_VAL;
      2'd2:    return cmd_byte(SEL_SETUP, 1'b0);
      default: return SETUP_VAL;
    endcase
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == LAST);
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_spi_byte.sv
module adc_spi_byte
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       rd_mode,
  input  logic       miso,
  output logic       idle,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       cs_n,
  output logic       sclk,
  output logic       mosi
);
  localparam int GAP_MIN = 2 * HALF_DIV;
  localparam int HCW     = $clog2(GAP_MIN + 2);

  eng_st_e    st_q, st_d;
  logic       ph_q, ph_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] rx_q, rx_d;
  logic       rd_q, rd_d;
  logic       cs_q, cs_d;
  logic       sck_q, sck_d;
  logic       tick;

  adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st_q != E_IDLE),
    .tick (tick)
  );

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    rx_d      = rx_q;
    rd_d      = rd_q;
    cs_d      = cs_q;
    sck_d     = sck_q;
    byte_done = 1'b0;
    case (st_q)
      E_IDLE: if (go) begin
        st_d  = E_SETUP;
        cs_d  = 1'b0;
        sh_d  = tx_byte;
        rd_d  = rd_mode;
        ph_d  = 1'b0;
        bit_d = '0;
      end
      E_SETUP: if (tick) begin
        if (ph_q) begin st_d = E_LOW; sck_d = 1'b0; ph_d = 1'b0; end
        else ph_d = 1'b1;
      end
      E_LOW: if (tick) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
        st_d  = E_HIGH;
      end
      E_HIGH: if (tick) begin
        if (bit_q == 3'd7) begin
          st_d = E_HOLD;
          ph_d = 1'b0;
        end else begin
          sck_d = 1'b0;
          sh_d  = {sh_q[6:0], 1'b0};
          bit_d = bit_q + 1'b1;
          st_d  = E_LOW;
        end
      end
      E_HOLD: if (tick) begin
        if (ph_q) begin cs_d = 1'b1; st_d = E_GAP; ph_d = 1'b0; end
        else ph_d = 1'b1;
      end
      E_GAP: if (tick) begin
        if (ph_q) begin st_d = E_IDLE; byte_done = 1'b1; ph_d = 1'b0; end
        else ph_d = 1'b1;
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= E_IDLE;
      ph_q  <= 1'b0;
      bit_q <= '0;
      sh_q  <= '0;
      rx_q  <= '0;
      rd_q  <= 1'b0;
      cs_q  <= 1'b1;
      sck_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      rx_q  <= rx_d;
      rd_q  <= rd_d;
      cs_q  <= cs_d;
      sck_q <= sck_d;
    end
  end

  assign idle    = (st_q == E_IDLE);
  assign rx_byte = rx_q;
  assign cs_n    = cs_q;
  assign sclk    = sck_q;
  assign mosi    = (cs_q || rd_q) ? 1'b1 : sh_q[7];

  // Checker: cycles with chip select high, saturating
  logic [HCW-1:0] hi_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hi_cnt_q <= HCW'(GAP_MIN);
    else if (!cs_q)                         hi_cnt_q <= '0;
    else if (hi_cnt_q < HCW'(GAP_MIN + 1))  hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(mosi));

  p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt_q >= HCW'(GAP_MIN)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] sample_count,
  input  logic             drdy_n,
  input  logic             eng_idle,
  input  logic             byte_done,
  input  logic [7:0]       rx_byte,
  output logic             go,
  output logic [7:0]       tx_byte,
  output logic             rd_mode,
  output logic             sample_valid,
  output logic [15:0]      sample_data,
  output logic             done
);
  localparam logic [1:0] CFG_LAST = 2'(CFG_LEN - 1);
  localparam logic [7:0] RD_CMD   = cmd_byte(SEL_DATA, 1'b1);

  ctl_st_e          st_q, st_d;
  logic [1:0]       idx_q, idx_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [7:0]       hi_q, hi_d;
  logic [15:0]      dat_q, dat_d;
  logic             vld_q, vld_d;
  logic             dn_q, dn_d;
  logic             rdy_m_q, rdy_s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_m_q <= 1'b1;
      rdy_s_q <= 1'b1;
    end else begin
      rdy_m_q <= drdy_n;
      rdy_s_q <= rdy_m_q;
    end
  end

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    go      = eng_idle && ((st_q == C_CFG) || (st_q == C_CMD) ||
                           (st_q == C_RDH) || (st_q == C_RDL));
    rd_mode = (st_q == C_RDH) || (st_q == C_RDL);
    if (st_q == C_CFG)      tx_byte = cfg_byte(idx_q);
    else if (st_q == C_CMD) tx_byte = RD_CMD;
    else                    tx_byte = IDLE_TX;
  end

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    tgt_d = tgt_q;
    cnt_d = cnt_q;
    hi_d  = hi_q;
    dat_d = dat_q;
    vld_d = 1'b0;
    dn_d  = dn_q;
    case (st_q)
      C_IDLE, C_DONE: if (start) begin
        st_d  = C_CFG;
        idx_d = '0;
        tgt_d = sample_count;
        cnt_d = '0;
        dn_d  = 1'b0;
      end
      C_CFG: if (byte_done) begin
        if (idx_q == CFG_LAST) begin
          if (tgt_q == '0) begin st_d = C_DONE; dn_d = 1'b1; end
          else st_d = C_WAIT_LO;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      C_WAIT_HI: if (rdy_s_q)  st_d = C_WAIT_LO;
      C_WAIT_LO: if (!rdy_s_q) st_d = C_CMD;
      C_CMD:     if (byte_done) st_d = C_RDH;
      C_RDH: if (byte_done) begin
        hi_d = rx_byte;
        st_d = C_RDL;
      end
      C_RDL: if (byte_done) begin
        dat_d = {hi_q, rx_byte};
        vld_d = 1'b1;
        cnt_d = cnt_inc;
        if (cnt_inc == tgt_q) begin st_d = C_DONE; dn_d = 1'b1; end
        else st_d = C_WAIT_HI;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      idx_q <= '0;
      tgt_q <= '0;
      cnt_q <= '0;
      hi_q  <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      tgt_q <= tgt_d;
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
      dn_q  <= dn_d;
    end
  end

  assign sample_valid = vld_q;
  assign sample_data  = dat_q;
  assign done         = dn_q;

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_done_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cnt_q == tgt_q));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int HALF_DIV = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] sample_count,
  input  logic             drdy_n,
  input  logic             miso,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             sample_valid,
  output logic [15:0]      sample_data,
  output logic             done
);
  logic       go, eng_idle, byte_done, rd_mode;
  logic [7:0] tx_byte, rx_byte;

  adc_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sample_count(sample_count),
    .drdy_n      (drdy_n),
    .eng_idle    (eng_idle),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .go          (go),
    .tx_byte     (tx_byte),
    .rd_mode     (rd_mode),
    .sample_valid(sample_valid),
    .sample_data (sample_data),
    .done        (done)
  );

  adc_spi_byte #(.HALF_DIV(HALF_DIV)) u_byte (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .tx_byte  (tx_byte),
    .rd_mode  (rd_mode),
    .miso     (miso),
    .idle     (eng_idle),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi)
  );

  p_mosi_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode && !cs_n) |-> mosi);

endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int HALF  = 4;
  localparam int CW    = 8;
  localparam int TCLK  = 20;
  localparam int GAP_T = 2 * HALF * TCLK;

  logic          clk = 1'b0;
  logic          rst_n, start, drdy_n;
  logic [CW-1:0] sample_count;
  logic          miso = 1'b1;
  logic          cs_n, sclk, mosi, sample_valid, done;
  logic [15:0]   sample_data;

  adc_seq_top #(.HALF_DIV(HALF), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_count(sample_count),
    .drdy_n(drdy_n), .miso(miso), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .sample_valid(sample_valid), .sample_data(sample_data), .done(done)
  );

  always #(TCLK/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;   // main flow
  int s_chk = 0, s_fail = 0;   // serial slave model
  int m_chk = 0, m_fail = 0;   // sample monitor
  int w_fail = 0;
  bit armed = 0;

  logic [15:0] samp [0:63];
  logic [7:0]  log_b [0:127];
  int          frames = 0;
  int          vcnt = 0;
  time         t_rise = 0;

  function automatic logic [7:0] exp_byte(int i);
    case (i)
      0: return 8'h20;
      1: return 8'h0C;
      2: return 8'h10;
      3: return 8'h40;
      default: return (((i - 4) % 3) == 0) ? 8'h38 : 8'hFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + s_chk + m_chk + (w_fail > 0 ? 1 : 0),
             n_fail + s_fail + m_fail + w_fail);
  endtask

  // Serial slave: mode 3, shifts out on falling sclk, samples on rising sclk
  logic       p_cs, p_sck, first_fall;
  int         bits, rd_left = 0, sidx = 0;
  logic [7:0] rxs, txs;
  time        t_fall, t_last_rise;
  always @(cs_n or sclk) begin
    if (armed) begin
      if (cs_n !== p_cs) begin
        if (!cs_n) begin
          s_chk++;
          if (($time - t_rise) < GAP_T) begin
            s_fail++;
            $display("FAIL R3 cs high gap actual=%0t expected>=%0d", $time - t_rise, GAP_T);
          end
          bits = 0; rxs = 8'h00; first_fall = 1'b1; t_fall = $time;
          txs = (rd_left == 2) ? samp[sidx][15:8] : (rd_left == 1) ? samp[sidx][7:0] : 8'h00;
          miso <= txs[7];
        end else begin
          s_chk += 2;
          if (bits != 8) begin
            s_fail++;
            $display("FAIL R3 sclk rises per frame actual=%0d expected=8", bits);
          end
          if (($time - t_last_rise) < GAP_T) begin
            s_fail++;
            $display("FAIL R3 cs hold actual=%0t expected>=%0d", $time - t_last_rise, GAP_T);
          end
          t_rise = $time;
          log_b[frames] = rxs;
          if (rd_left > 0) begin
            s_chk++;
            if (rxs != 8'hFF) begin
              s_fail++;
              $display("FAIL R6 mosi during read actual=%0h expected=ff", rxs);
            end
            rd_left--;
            if (rd_left == 0) sidx++;
          end else if (rxs == 8'h38) begin
            rd_left = 2;
          end
          frames++;
        end
      end else if (sclk !== p_sck && !cs_n) begin
        if (!sclk) begin
          if (first_fall) begin
            first_fall = 1'b0;
            s_chk++;
            if (($time - t_fall) < GAP_T) begin
              s_fail++;
              $display("FAIL R3 cs setup actual=%0t expected>=%0d", $time - t_fall, GAP_T);
            end
          end else begin
            txs = {txs[6:0], 1'b0};
            miso <= txs[7];
          end
        end else begin
          rxs = {rxs[6:0], mosi};
          bits++;
          t_last_rise = $time;
        end
      end
    end
    p_cs  = cs_n;
    p_sck = sclk;
  end

  // Sample monitor: value and exact strobe timing
  always @(negedge clk) begin
    if (armed && sample_valid) begin
      m_chk += 2;
      if (sample_data !== samp[vcnt]) begin
        m_fail++;
        $display("FAIL R7 sample data actual=%0h expected=%0h", sample_data, samp[vcnt]);
      end
      if (($time - t_rise) != GAP_T + TCLK/2) begin
        m_fail++;
        $display("FAIL R7 strobe delay actual=%0t expected=%0d", $time - t_rise, GAP_T + TCLK/2);
      end
      vcnt++;
    end
  end

  task automatic run(input int n, input bit poke);
    int base, vbase, d;
    base  = frames;
    vbase = vcnt;
    for (int k = 0; k < n; k++) samp[sidx + k] = 16'($urandom);
    if (n > 1) begin
      samp[sidx]         = 16'h8000;
      samp[sidx + n - 1] = 16'h00FF;
    end
    drdy_n = 1'b1;
    sample_count = CW'(n);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      wait (frames == base + 1);
      @(negedge clk) begin start = 1'b1; sample_count = '0; end
      @(negedge clk) begin start = 1'b0; sample_count = CW'(n); end
    end
    wait (frames == base + 4);
    d = 20 + int'($urandom % 40);
    repeat (d) @(negedge clk);
    chk(frames == base + 4 && cs_n == 1'b1, "R5 no byte before ready", frames - base, 4);
    if (n == 0) begin
      chk(done == 1'b1, "R11 done after config", done, 1);
      chk(vcnt == vbase, "R11 no sample", vcnt - vbase, 0);
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk) drdy_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R5 cs still high 3 edges after ready", cs_n, 1);
      @(negedge clk);
      chk(cs_n == 1'b0, "R5 cs low 4 edges after ready", cs_n, 0);
      wait (frames == base + 4 + 3 * (k + 1));
      if (k == 0 && n > 1) begin
        repeat (30) @(negedge clk);
        chk(frames == base + 7, "R8 ready held low starts no read", frames - base, 7);
      end
      @(negedge clk) drdy_n = 1'b1;
      d = 2 * HALF + 10 + int'($urandom % 30);
      repeat (d) @(negedge clk);
      chk(frames == base + 4 + 3 * (k + 1), "R8 waits for ready",
          frames - base, 4 + 3 * (k + 1));
      chk(done == (k == n - 1), "R9 done only at last sample", done, int'(k == n - 1));
    end
    chk(vcnt - vbase == n, "R7 strobe count", vcnt - vbase, n);
    @(negedge clk) drdy_n = 1'b0;
    repeat (60) @(negedge clk);
    chk(done == 1'b1 && frames == base + 4 + 3 * n, "R9 done holds, link quiet",
        frames - base, 4 + 3 * n);
    for (int i = 0; i < 4 + 3 * n; i++)
      chk(log_b[base + i] == exp_byte(i), (i < 4) ? "R4 config byte" : "R6 read byte",
          log_b[base + i], exp_byte(i));
  endtask

  initial begin
    void'($urandom(32'h0000_5A17));
    rst_n = 1'b0; start = 1'b0; drdy_n = 1'b1; sample_count = '0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 link idle in reset", {cs_n, sclk}, 3);
    chk(sample_valid == 1'b0 && done == 1'b0, "R1 outputs low in reset",
        {sample_valid, done}, 0);
    rst_n = 1'b1;
    armed = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1 && done == 1'b0, "R1 idle after reset", {cs_n, done}, 2);
    run(5, 1'b1);   // R10 start during sequence ignored
    run(0, 1'b0);   // R11 empty request, R10 restart from done
    run(7, 1'b0);   // R10 restart again with a new count
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    w_fail = 1;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

endmodule